// File: doc/BRIEF.md
# Combined-Operation Accumulator ALU Unit

This unit executes the fused opcodes of an 8-bit accumulator processor, where a single opcode performs two steps in sequence. Some opcodes modify a memory operand, write it back, and feed the new value into an accumulator operation. Others combine an AND with a shift or rotate. A few simply move data between the accumulator, the X index and memory. The processor core fetches the operand and generates addresses elsewhere. It hands this unit the opcode byte, the A, X and S registers, the memory operand byte and the current N, V, Z and C flags, together with a one-cycle strobe.

One clock after an accepted strobe, the unit presents the new A, X and S values and a write-back byte with its write-enable, along with the updated flags and a result-valid pulse. Flags always come from the final step of the chain, and some opcodes apply their own carry rules. The halt opcodes latch a sticky halt output. From then on the unit refuses all strobes until a synchronous reset.

Top module: `combo_op_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared to zero, including `halted`, `res_valid` and `mem_we`.
- R2: A strobe on `op_valid` while not halted produces `res_valid` high on the following clock only. In cycles without a strobe, `res_valid` and `mem_we` are low, and A, X, S, memory byte and flag outputs hold their previous values.
- R3: Opcodes 0x0B and 0x2B: A receives A AND M. N and Z follow the result, C receives the result's bit 7, and V passes through unchanged.
- R4: Opcode 0x4B: t = A AND M, and A receives t shifted right logically by one. N is cleared, Z follows the new A, C receives bit 0 of t, and V passes through.
- R5: Opcode 0x6B: t = A AND M, and A receives {C_in, t[7:1]}. N and Z follow the new A, C receives bit 6 of the new A, and V receives bit 6 XOR bit 5 of the new A.
- R6: Opcodes 0x07, 0x17, 0x0F, 0x1F, 0x1B, 0x03 and 0x13: M is shifted left by one with a zero fill and written back. A receives A OR new M. N and Z follow the new A, and C receives the old bit 7 of M.
- R7: Opcodes 0x47, 0x57, 0x4F, 0x5F, 0x5B, 0x43 and 0x53: M is shifted right logically by one and written back. A receives A XOR new M. N and Z follow the new A, and C receives the old bit 0 of M.
- R8: Opcodes 0xC7, 0xD7, 0xCF, 0xDF, 0xDB, 0xC3 and 0xD3: M − 1 (mod 256) is written back, and A is unchanged. C is set when A ≥ new M, Z is set when A = new M, and N receives bit 7 of (A − new M).
- R9: Opcodes 0xE7, 0xF7, 0xEF, 0xFF, 0xFB, 0xE3 and 0xF3: M + 1 (mod 256) is written back, and A receives A + NOT(new M) + C_in. C receives the carry out. V is set when A and new M differ in bit 7 and the result differs from A in bit 7. N and Z follow the result.
- R10: Opcodes 0xA7, 0xB7, 0xAF, 0xBF, 0xA3, 0xB3 and 0xAB: both A and X receive M. N and Z follow M, while V and C pass through, and nothing is written to memory.
- R11: Opcodes 0x87, 0x97, 0x8F and 0x83: the write-back byte is A AND X with the write-enable high. All four flags, A and X are unchanged.
- R12: Opcode 0xCB: X receives (A AND X) − M (mod 256), and A is unchanged. N and Z follow the new X, C is set when (A AND X) ≥ M, and V passes through.
- R13: Opcodes 0x02, 0x12, 0x22, 0x32, 0x42, 0x52, 0x62, 0x72, 0x92, 0xB2, 0xD2 and 0xF2 complete with registers and flags passed through and raise `halted`. While `halted` is high, strobes produce no result and change no output. Only reset clears `halted`.
- R14: Any other opcode (for example 0xEA, 0x82, 0x8B) completes with A, X, S and all flags equal to their inputs, `mem_out` equal to M and `mem_we` low. S always passes through, and `mem_we` is high only for the groups of R6 to R9 and R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle strobe: execute `opcode` on the operands |
| opcode | input | 8 | Opcode byte |
| a_in | input | 8 | Accumulator |
| x_in | input | 8 | X index register |
| s_in | input | 8 | Stack pointer |
| mem_in | input | 8 | Memory operand byte |
| n_in | input | 1 | Current negative flag |
| v_in | input | 1 | Current overflow flag |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| res_valid | output | 1 | Result valid, one clock after an accepted strobe |
| a_out | output | 8 | New accumulator |
| x_out | output | 8 | New X |
| s_out | output | 8 | New stack pointer |
| mem_out | output | 8 | Write-back byte |
| mem_we | output | 1 | Write-back enable, valid with `res_valid` |
| n_out | output | 1 | New negative flag |
| v_out | output | 1 | New overflow flag |
| z_out | output | 1 | New zero flag |
| c_out | output | 1 | New carry flag |
| halted | output | 1 | Sticky halt indication |

## Verification
Each fused group is driven with operands chosen to separate the two steps. Memory bytes with bit 7 or bit 0 set expose whether the carry comes from the old or the new memory value. Equal, smaller and larger compare operands tell the three outcomes of the decrement-compare apart. A signed-overflow case for the increment-subtract shows whether the new or the old memory byte enters the subtraction. Carry-in of 0 and 1 on the rotate, distinct incoming flag patterns on the store and the unsupported opcodes, and strobes after a halt show that untouched state really passes through. Back-to-back strobes and idle gaps also check that results and held values line up with the one-clock latency.

// File: rtl/combo_op_pkg.sv
package combo_op_pkg;
  localparam int OPW = 8;

  typedef enum logic [3:0] {
    K_NONE,
    K_AND_NC,
    K_AND_LSR,
    K_AND_ROR,
    K_SHL_OR,
    K_SHR_XOR,
    K_DEC_CMP,
    K_INC_SBC,
    K_LOAD_AX,
    K_STORE_AX,
    K_AX_SUB,
    K_HALT
  } op_kind_e;
endpackage

// File: rtl/combo_op_decode.sv
module combo_op_decode
  import combo_op_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  output op_kind_e       kind
);
  logic halt_code;

  // halt codes: low nibble 2, excluding the x2 codes with bit7 set and bit4 clear
  assign halt_code = (opcode[3:0] == 4'h2) && (!opcode[7] || opcode[4]);

  always_comb begin
    case (opcode)
      8'h0B, 8'h2B:                                     kind = K_AND_NC;
      8'h4B:                                            kind = K_AND_LSR;
      8'h6B:                                            kind = K_AND_ROR;
      8'h07, 8'h17, 8'h0F, 8'h1F, 8'h1B, 8'h03, 8'h13: kind = K_SHL_OR;
      8'h47, 8'h57, 8'h4F, 8'h5F, 8'h5B, 8'h43, 8'h53: kind = K_SHR_XOR;
      8'hC7, 8'hD7, 8'hCF, 8'hDF, 8'hDB, 8'hC3, 8'hD3: kind = K_DEC_CMP;
      8'hE7, 8'hF7, 8'hEF, 8'hFF, 8'hFB, 8'hE3, 8'hF3: kind = K_INC_SBC;
      8'hA7, 8'hB7, 8'hAF, 8'hBF, 8'hA3, 8'hB3, 8'hAB: kind = K_LOAD_AX;
      8'h87, 8'h97, 8'h8F, 8'h83:                       kind = K_STORE_AX;
      8'hCB:                                            kind = K_AX_SUB;
      default:                                          kind = halt_code ? K_HALT : K_NONE;
    endcase
  end
endmodule

// File: rtl/combo_op_mem_stage.sv
module combo_op_mem_stage
  import combo_op_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_kind_e        kind,
  input  logic [DW-1:0]   m,
  output logic [DW-1:0]   m_new,
  output logic            lost_bit
);
  always_comb begin
    m_new    = m;
    lost_bit = 1'b0;
    case (kind)
      K_SHL_OR: begin
        m_new    = {m[DW-2:0], 1'b0};
        lost_bit = m[DW-1];
      end
      K_SHR_XOR: begin
        m_new    = {1'b0, m[DW-1:1]};
        lost_bit = m[0];
      end
      K_DEC_CMP: m_new = m - DW'(1);
      K_INC_SBC: m_new = m + DW'(1);
      default: ;
    endcase
  end
endmodule

// File: rtl/combo_op_acc_stage.sv
module combo_op_acc_stage
  import combo_op_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_kind_e        kind,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   x,
  input  logic [DW-1:0]   m,
  input  logic [DW-1:0]   m_new,
  input  logic            lost_bit,
  input  logic            n_i,
  input  logic            v_i,
  input  logic            z_i,
  input  logic            c_i,
  output logic [DW-1:0]   a_o,
  output logic [DW-1:0]   x_o,
  output logic [DW-1:0]   mem_o,
  output logic            we_o,
  output logic            n_o,
  output logic            v_o,
  output logic            z_o,
  output logic            c_o,
  output logic            halt_o
);
  localparam int SB = DW - 1;

  logic [DW-1:0] anded, ax, r;
  logic [DW:0]   wide;

  assign anded = a & m;
  assign ax    = a & x;

  always_comb begin
    a_o    = a;
    x_o    = x;
    mem_o  = m;
    we_o   = 1'b0;
    n_o    = n_i;
    v_o    = v_i;
    z_o    = z_i;
    c_o    = c_i;
    halt_o = 1'b0;
    r      = '0;
    wide   = '0;
    case (kind)
      K_AND_NC: begin
        a_o = anded;
        n_o = anded[SB];
        z_o = ~|anded;
        c_o = anded[SB];
      end
      K_AND_LSR: begin
        r   = {1'b0, anded[SB:1]};
        a_o = r;
        n_o = 1'b0;
        z_o = ~|r;
        c_o = anded[0];
      end
      K_AND_ROR: begin
        r   = {c_i, anded[SB:1]};
        a_o = r;
        n_o = r[SB];
        z_o = ~|r;
        c_o = r[SB-1];
        v_o = r[SB-1] ^ r[SB-2];
      end
      K_SHL_OR: begin
        r     = a | m_new;
        a_o   = r;
        mem_o = m_new;
        we_o  = 1'b1;
        n_o   = r[SB];
        z_o   = ~|r;
        c_o   = lost_bit;
      end
      K_SHR_XOR: begin
        r     = a ^ m_new;
        a_o   = r;
        mem_o = m_new;
        we_o  = 1'b1;
        n_o   = r[SB];
        z_o   = ~|r;
        c_o   = lost_bit;
      end
      K_DEC_CMP: begin
        wide  = {1'b0, a} - {1'b0, m_new};
        mem_o = m_new;
        we_o  = 1'b1;
        n_o   = wide[SB];
        z_o   = (a == m_new);
        c_o   = ~wide[DW];
      end
      K_INC_SBC: begin
        wide  = {1'b0, a} + {1'b0, ~m_new} + {{DW{1'b0}}, c_i};
        r     = wide[SB:0];
        a_o   = r;
        mem_o = m_new;
        we_o  = 1'b1;
        n_o   = r[SB];
        z_o   = ~|r;
        c_o   = wide[DW];
        v_o   = (a[SB] ^ m_new[SB]) & (a[SB] ^ r[SB]);
      end
      K_LOAD_AX: begin
        a_o = m;
        x_o = m;
        n_o = m[SB];
        z_o = ~|m;
      end
      K_STORE_AX: begin
        mem_o = ax;
        we_o  = 1'b1;
      end
      K_AX_SUB: begin
        wide = {1'b0, ax} - {1'b0, m};
        x_o  = wide[SB:0];
        n_o  = wide[SB];
        z_o  = ~|wide[SB:0];
        c_o  = ~wide[DW];
      end
      K_HALT:  halt_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/combo_op_unit.sv
module combo_op_unit
  import combo_op_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [OPW-1:0]  opcode,
  input  logic [DW-1:0]   a_in,
  input  logic [DW-1:0]   x_in,
  input  logic [DW-1:0]   s_in,
  input  logic [DW-1:0]   mem_in,
  input  logic            n_in,
  input  logic            v_in,
  input  logic            z_in,
  input  logic            c_in,
  output logic            res_valid,
  output logic [DW-1:0]   a_out,
  output logic [DW-1:0]   x_out,
  output logic [DW-1:0]   s_out,
  output logic [DW-1:0]   mem_out,
  output logic            mem_we,
  output logic            n_out,
  output logic            v_out,
  output logic            z_out,
  output logic            c_out,
  output logic            halted
);
  op_kind_e      kind;
  logic [DW-1:0] m_new, a_nx, x_nx, mem_nx;
  logic          lost_bit, we_nx, n_nx, v_nx, z_nx, c_nx, halt_nx;
  logic          accept;

  combo_op_decode u_decode (
    .opcode (opcode),
    .kind   (kind)
  );

  combo_op_mem_stage #(.DW(DW)) u_mem (
    .kind     (kind),
    .m        (mem_in),
    .m_new    (m_new),
    .lost_bit (lost_bit)
  );

  combo_op_acc_stage #(.DW(DW)) u_acc (
    .kind     (kind),
    .a        (a_in),
    .x        (x_in),
    .m        (mem_in),
    .m_new    (m_new),
    .lost_bit (lost_bit),
    .n_i      (n_in),
    .v_i      (v_in),
    .z_i      (z_in),
    .c_i      (c_in),
    .a_o      (a_nx),
    .x_o      (x_nx),
    .mem_o    (mem_nx),
    .we_o     (we_nx),
    .n_o      (n_nx),
    .v_o      (v_nx),
    .z_o      (z_nx),
    .c_o      (c_nx),
    .halt_o   (halt_nx)
  );

  assign accept = op_valid & ~halted;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      mem_we    <= 1'b0;
      a_out     <= '0;
      x_out     <= '0;
      s_out     <= '0;
      mem_out   <= '0;
      n_out     <= 1'b0;
      v_out     <= 1'b0;
      z_out     <= 1'b0;
      c_out     <= 1'b0;
      halted    <= 1'b0;
    end else begin
      res_valid <= accept;
      mem_we    <= accept & we_nx;
      if (accept) begin
        a_out   <= a_nx;
        x_out   <= x_nx;
        s_out   <= s_in;
        mem_out <= mem_nx;
        n_out   <= n_nx;
        v_out   <= v_nx;
        z_out   <= z_nx;
        c_out   <= c_nx;
        if (halt_nx) halted <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/combo_op_unit_chk.sv
module combo_op_unit_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic [7:0]    opcode,
  input logic [DW-1:0] a_in,
  input logic [DW-1:0] x_in,
  input logic [DW-1:0] mem_in,
  input logic          res_valid,
  input logic [DW-1:0] a_out,
  input logic [DW-1:0] x_out,
  input logic [DW-1:0] mem_out,
  input logic          mem_we,
  input logic          n_out,
  input logic          halted
);
  logic live;
  assign live = op_valid && !halted;

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);                                                   // R13
  AST_HALT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    halted |=> !res_valid);                                               // R13
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!res_valid && !mem_we));                               // R2
  AST_WE_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> res_valid);                                                // R14
  AST_LSR_N_LOW: assert property (@(posedge clk) disable iff (rst)
    (live && opcode == 8'h4B) |=> !n_out);                                // R4
  AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (rst)
    (live && opcode inside {8'hA7, 8'hB7, 8'hAF, 8'hBF, 8'hA3, 8'hB3, 8'hAB})
    |=> (a_out == x_out && a_out == $past(mem_in) && !mem_we));           // R10
  AST_STORE_AX: assert property (@(posedge clk) disable iff (rst)
    (live && opcode inside {8'h87, 8'h97, 8'h8F, 8'h83})
    |=> (mem_we && mem_out == $past(a_in & x_in)));                       // R11
  AST_UNSUP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (live && opcode == 8'hEA)
    |=> (!mem_we && a_out == $past(a_in) && x_out == $past(x_in)));       // R14
endmodule

bind combo_op_unit combo_op_unit_chk #(.DW(DW)) u_chk (.*);

// File: tb/combo_op_unit_tb.sv
`timescale 1ns/1ps
module combo_op_unit_tb;
  typedef struct packed {
    logic       rv;
    logic [7:0] a, x, s, m;
    logic       we, fn, fv, fz, fc, hl;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1, op_valid = 1'b0;
  logic [7:0] opcode = '0, a_in = '0, x_in = '0, s_in = '0, mem_in = '0;
  logic n_in = 1'b0, v_in = 1'b0, z_in = 1'b0, c_in = 1'b0;
  logic res_valid, mem_we, n_out, v_out, z_out, c_out, halted;
  logic [7:0] a_out, x_out, s_out, mem_out;

  int checks = 0, errors = 0;
  bit finished = 1'b0, bench_halted = 1'b0;
  exp_t last = '0;
  exp_t exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  combo_op_unit u_dut (.*);

  function automatic exp_t observed();
    return {res_valid, a_out, x_out, s_out, mem_out, mem_we, n_out, v_out, z_out, c_out, halted};
  endfunction

  task automatic check(input string tag, input exp_t got, input exp_t want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, got, want);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic exp_t model(input logic [7:0] op, a, x, s, m, input logic [3:0] fl);
    exp_t e;
    logic [7:0] r, mm, t;
    logic [8:0] w;
    e = '0;
    e.rv = 1'b1; e.a = a; e.x = x; e.s = s; e.m = m;
    {e.fn, e.fv, e.fz, e.fc} = fl;
    e.hl = bench_halted;
    if (op inside {8'h0B, 8'h2B}) begin
      r = a & m; e.a = r; e.fn = r[7]; e.fz = (r == 0); e.fc = r[7];
    end else if (op == 8'h4B) begin
      t = a & m; r = t >> 1; e.a = r; e.fn = 1'b0; e.fz = (r == 0); e.fc = t[0];
    end else if (op == 8'h6B) begin
      t = a & m; r = {fl[0], t[7:1]}; e.a = r;
      e.fn = r[7]; e.fz = (r == 0); e.fc = r[6]; e.fv = r[6] ^ r[5];
    end else if (op inside {8'h07, 8'h17, 8'h0F, 8'h1F, 8'h1B, 8'h03, 8'h13}) begin
      mm = m << 1; r = a | mm; e.a = r; e.m = mm; e.we = 1'b1;
      e.fn = r[7]; e.fz = (r == 0); e.fc = m[7];
    end else if (op inside {8'h47, 8'h57, 8'h4F, 8'h5F, 8'h5B, 8'h43, 8'h53}) begin
      mm = m >> 1; r = a ^ mm; e.a = r; e.m = mm; e.we = 1'b1;
      e.fn = r[7]; e.fz = (r == 0); e.fc = m[0];
    end else if (op inside {8'hC7, 8'hD7, 8'hCF, 8'hDF, 8'hDB, 8'hC3, 8'hD3}) begin
      mm = m - 8'd1; r = a - mm; e.m = mm; e.we = 1'b1;
      e.fn = r[7]; e.fz = (a == mm); e.fc = (a >= mm);
    end else if (op inside {8'hE7, 8'hF7, 8'hEF, 8'hFF, 8'hFB, 8'hE3, 8'hF3}) begin
      mm = m + 8'd1; w = {1'b0, a} + {1'b0, ~mm} + {8'd0, fl[0]}; r = w[7:0];
      e.a = r; e.m = mm; e.we = 1'b1; e.fn = r[7]; e.fz = (r == 0); e.fc = w[8];
      e.fv = (a[7] != mm[7]) && (r[7] != a[7]);
    end else if (op inside {8'hA7, 8'hB7, 8'hAF, 8'hBF, 8'hA3, 8'hB3, 8'hAB}) begin
      e.a = m; e.x = m; e.fn = m[7]; e.fz = (m == 0);
    end else if (op inside {8'h87, 8'h97, 8'h8F, 8'h83}) begin
      e.m = a & x; e.we = 1'b1;
    end else if (op == 8'hCB) begin
      t = a & x; r = t - m; e.x = r; e.fn = r[7]; e.fz = (r == 0); e.fc = (t >= m);
    end else if (op inside {8'h02, 8'h12, 8'h22, 8'h32, 8'h42, 8'h52, 8'h62, 8'h72,
                            8'h92, 8'hB2, 8'hD2, 8'hF2}) begin
      e.hl = 1'b1;
    end
    return e;
  endfunction

  // driver: one strobe per call, expected item queued when the unit should answer
  task automatic issue(input logic [7:0] op, a, x, s, m, input logic [3:0] fl, input string tag);
    exp_t e;
    @(negedge clk);
    opcode = op; a_in = a; x_in = x; s_in = s; mem_in = m;
    {n_in, v_in, z_in, c_in} = fl;
    op_valid = 1'b1;
    if (!bench_halted) begin
      e = model(op, a, x, s, m, fl);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      last = e;
      bench_halted = e.hl;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    op_valid = 1'b0; rst = 1'b1;
    last = '0; bench_halted = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // monitor: 1 ns after each rising edge
  initial begin
    forever begin
      exp_t hold;
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
        check(tag_q.pop_front(), observed(), exp_q.pop_front());
      end else begin
        hold = last; hold.rv = 1'b0; hold.we = 1'b0;
        check(rst ? "R1" : (bench_halted ? "R13" : "R2"), observed(), hold);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: got 20000 cycles exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", observed(), '0);
    rst = 1'b0;
    issue(8'h0B, 8'hF0, 8'h11, 8'h5A, 8'h9C, 4'b0100, "R3 neg");
    issue(8'h2B, 8'h0F, 8'h22, 8'h5A, 8'hF0, 4'b1001, "R3 zero");
    issue(8'h4B, 8'hFF, 8'h00, 8'h33, 8'hC3, 4'b1100, "R4 odd");
    issue(8'h4B, 8'h02, 8'h00, 8'h33, 8'h03, 4'b1000, "R4 even");
    issue(8'h6B, 8'hC0, 8'h00, 8'h10, 8'hFF, 4'b0001, "R5 cin1");
    issue(8'h6B, 8'hA0, 8'h00, 8'h10, 8'hFF, 4'b0100, "R5 cin0");
    idle(3);
    issue(8'h07, 8'h01, 8'h00, 8'h44, 8'h81, 4'b0000, "R6 bit7");
    issue(8'h1B, 8'h00, 8'h00, 8'h44, 8'h40, 4'b0001, "R6 nocarry");
    issue(8'h47, 8'hFF, 8'h00, 8'h44, 8'h03, 4'b0000, "R7 bit0");
    issue(8'h5F, 8'h7F, 8'h00, 8'h44, 8'hFE, 4'b1001, "R7 even");
    issue(8'hC7, 8'h41, 8'h00, 8'h77, 8'h42, 4'b0000, "R8 equal");
    issue(8'hD3, 8'h10, 8'h00, 8'h77, 8'h40, 4'b0000, "R8 less");
    issue(8'hCF, 8'h90, 8'h00, 8'h77, 8'h00, 4'b0100, "R8 wrap");
    issue(8'hE7, 8'h80, 8'h00, 8'h77, 8'h00, 4'b0001, "R9 overflow");
    issue(8'hFF, 8'h05, 8'h00, 8'h77, 8'hFF, 4'b0000, "R9 wrap borrow");
    idle(2);
    issue(8'hA7, 8'h12, 8'h34, 8'h99, 8'h80, 4'b0101, "R10 neg");
    issue(8'hAB, 8'h12, 8'h34, 8'h99, 8'h00, 4'b0001, "R10 zero");
    issue(8'h87, 8'hF3, 8'h3C, 8'h99, 8'h55, 4'b1111, "R11 flags1");
    issue(8'h83, 8'hAA, 8'hFF, 8'h99, 8'h55, 4'b0000, "R11 flags0");
    issue(8'hCB, 8'hF0, 8'h3C, 8'h21, 8'h10, 4'b0100, "R12 carry");
    issue(8'hCB, 8'h0F, 8'h03, 8'h21, 8'h04, 4'b0001, "R12 borrow");
    issue(8'hEA, 8'h11, 8'h22, 8'h33, 8'h44, 4'b1010, "R14 nop");
    issue(8'h82, 8'h55, 8'h66, 8'h77, 8'h88, 4'b0101, "R14 x2 not halt");
    issue(8'h8B, 8'hFF, 8'hFF, 8'hEE, 8'hFF, 4'b1111, "R14 unstable");
    idle(3);
    issue(8'hB2, 8'h9A, 8'hBC, 8'hDE, 8'hF0, 4'b0110, "R13 halt");
    issue(8'h0B, 8'hFF, 8'h00, 8'h01, 8'hFF, 4'b0000, "R13 ignored");
    issue(8'h07, 8'hFF, 8'h00, 8'h01, 8'hFF, 4'b0000, "R13 ignored");
    idle(3);
    do_reset();
    idle(1);
    issue(8'h2B, 8'h81, 8'h00, 8'h02, 8'h80, 4'b0000, "R13 cleared by R1");
    idle(3);
    finish_run();
  end
endmodule